// File: doc/BRIEF.md
# Pad-to-channel interrupt multiplexer

This block lets software pick, for each of a small set of interrupt channels, one pad out of a large pool of pad inputs, and sets how the chosen pad signal is turned into an interrupt request. Each channel output is wired to a fixed line of a downstream interrupt controller, so that controller never has to see every pad. The downstream controller only accepts active-high levels or rising edges. This block therefore inverts the input where needed and reduces edges to one-cycle pulses, so falling edges, both edges and active-low levels can all be used.

Software programs the block through a plain 32-bit register bus. Every write stores a full word. Reads are combinational on the address. Pads are asynchronous and pass through a two-flop synchroniser before the per-channel selector. A per-channel glitch-filter selection is stored and driven out next to the requests for the conditioner that follows. A layout parameter picks one of two register arrangements: the default one, or a narrower one that adds a global enable.

Top module: `padirq_mux`

## Requirements
- R1: After reset every mapped register reads zero, `irq_out` is zero while the pads are low, and `filt_sel` is zero.
- R2: Offset 0x00 holds three per-channel lanes: edge mode in bits 0..7, both-edge mode in bits 8..15 and inversion in bits 16..23. In the default layout the other bits read zero, so writing 0xFFFFFFFF reads back 0x00FFFFFF.
- R3: In the default layout, offset 0x04 holds the 8-bit pad selectors of channels 0..3 and offset 0x08 holds those of channels 4..7, with channel n at bit (n mod 4)*8. A selected pad drives that channel and no other channel.
- R4: In the default layout, offset 0x0c holds a 4-bit filter selection per channel, with channel n at bit n*4. The word is driven on `filt_sel` with the same packing.
- R5: Writes to unmapped offsets change no register, and reads of those offsets return zero.
- R6: With edge and both-edge off, a channel is level sensitive: `irq_out[n]` equals the selected pad XOR the inversion bit. A pad change shows on the output after the third rising clock edge.
- R7: With edge mode on and both-edge off, a channel gives a single one-cycle pulse on a rising pad edge when inversion is 0, or on a falling pad edge when inversion is 1. The pulse shows after the third clock edge. The opposite edge gives no pulse.
- R8: Both-edge mode takes precedence over the edge and inversion bits: a one-cycle pulse follows every pad transition.
- R9: In the cycle after a channel's selector changes, the edge history is reloaded from the new pad and no edge is reported. This holds even when the new pad differs from the old one, and when a new-pad transition reaches the synchroniser output in that same cycle. Later edges of the new pad are reported.
- R10: In the alternate layout (LAYOUT=1), bit 31 of offset 0x00 is a global enable. It resets to 0 and reads back. While it is 0 all outputs are low, and it takes effect at the second clock edge after the write.
- R11: In the alternate layout, 7-bit selectors are packed two per register from offset 0x04, with even channels at bit 0 and odd channels at bit 16. The filter word is at 0x14, and writing 0xFFFFFFFF to 0x04 reads back 0x007F007F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Full-word register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| irq_out | output | NUM_CHAN | Per-channel active-high request |
| filt_sel | output | NUM_CHAN*4 | Per-channel filter selection |

## Verification
The two functions that can fall in the same cycle are a selector switch and a pad transition arriving at the synchroniser output. The bench sets the new pad one cycle before issuing the selector write, so that the second synchroniser stage and the selector register update on the same clock edge. The channel must then stay silent: no pulse in that cycle or in the cycles that follow. After that, a fresh edge on the new pad must give exactly one pulse, which shows the history was reloaded and not merely masked.

// File: rtl/padirq_pkg.sv
package padirq_pkg;
   localparam int TRIG_ADDR = 0;
   localparam int EDGE_LSB  = 0;
   localparam int BOTH_LSB  = 8;
   localparam int INV_LSB   = 16;
   localparam int GEN_BIT   = 31;
   localparam int FILT_W    = 4;

   function automatic int sel_width(input int layout);
      return (layout == 1) ? 7 : 8;
   endfunction

   function automatic int sel_addr(input int layout, input int ch);
      if (layout == 1) return 4 + (ch / 2) * 4;
      return (ch < 4) ? 4 : 8;
   endfunction

   function automatic int sel_lsb(input int layout, input int ch);
      if (layout == 1) return (ch % 2) * 16;
      return (ch % 4) * 8;
   endfunction

   function automatic int filt_addr(input int layout);
      return (layout == 1) ? 20 : 12;
   endfunction
endpackage

// File: rtl/padirq_sync.sv
module padirq_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/padirq_regs.sv
module padirq_regs
   import padirq_pkg::*;
#(
   parameter int LAYOUT   = 0,
   parameter int NUM_CHAN = 8,
   parameter int ADDR_W   = 8,
   parameter int SELW     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   output logic [NUM_CHAN*SELW-1:0]   sel_q,
   output logic [NUM_CHAN-1:0]        edge_q,
   output logic [NUM_CHAN-1:0]        both_q,
   output logic [NUM_CHAN-1:0]        inv_q,
   output logic [NUM_CHAN*FILT_W-1:0] filt_q,
   output logic                       glb_en
);
   localparam bit               HAS_GEN = (LAYOUT == 1);
   localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);
   localparam logic [ADDR_W-1:0] FILT_A = ADDR_W'(filt_addr(LAYOUT));

   logic gen_q;
   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         edge_q <= '0;
         both_q <= '0;
         inv_q  <= '0;
         filt_q <= '0;
         gen_q  <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == TRIG_A) begin
            edge_q <= reg_wdata[EDGE_LSB +: NUM_CHAN];
            both_q <= reg_wdata[BOTH_LSB +: NUM_CHAN];
            inv_q  <= reg_wdata[INV_LSB +: NUM_CHAN];
            gen_q  <= HAS_GEN ? reg_wdata[GEN_BIT] : 1'b0;
         end
         if (reg_addr == FILT_A)
            filt_q <= reg_wdata[NUM_CHAN*FILT_W-1:0];
         for (int c = 0; c < NUM_CHAN; c++) begin
            if (reg_addr == ADDR_W'(sel_addr(LAYOUT, c)))
               sel_q[c*SELW +: SELW] <= reg_wdata[sel_lsb(LAYOUT, c) +: SELW];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == TRIG_A) begin
         reg_rdata[EDGE_LSB +: NUM_CHAN] = edge_q;
         reg_rdata[BOTH_LSB +: NUM_CHAN] = both_q;
         reg_rdata[INV_LSB +: NUM_CHAN]  = inv_q;
         if (HAS_GEN) reg_rdata[GEN_BIT] = gen_q;
      end
      if (reg_addr == FILT_A)
         reg_rdata[NUM_CHAN*FILT_W-1:0] = filt_q;
      for (int c = 0; c < NUM_CHAN; c++) begin
         if (reg_addr == ADDR_W'(sel_addr(LAYOUT, c)))
            reg_rdata[sel_lsb(LAYOUT, c) +: SELW] = sel_q[c*SELW +: SELW];
      end
   end

   assign glb_en = HAS_GEN ? gen_q : 1'b1;
endmodule

// File: rtl/padirq_chan.sv
module padirq_chan #(
   parameter int SELW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl,
   input  logic [SELW-1:0] sel,
   input  logic            edge_en,
   input  logic            both_en,
   input  logic            inv_en,
   input  logic            gate,
   output logic            irq
);
   logic            prev;
   logic [SELW-1:0] sel_seen;
   logic            fresh;
   logic            hit;

   assign fresh = (sel == sel_seen);

   always_comb begin
      if (both_en)      hit = fresh & (lvl ^ prev);
      else if (edge_en) hit = fresh & (inv_en ? (prev & ~lvl) : (lvl & ~prev));
      else              hit = lvl ^ inv_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= 1'b0;
         sel_seen <= '0;
         irq      <= 1'b0;
      end else begin
         prev     <= lvl;
         sel_seen <= sel;
         irq      <= gate & hit;
      end
   end
endmodule

// File: rtl/padirq_mux.sv
module padirq_mux
   import padirq_pkg::*;
#(
   parameter int LAYOUT   = 0,
   parameter int NUM_PADS = 256,
   parameter int NUM_CHAN = 8,
   parameter int ADDR_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   input  logic [NUM_PADS-1:0]        pad_in,
   output logic [NUM_CHAN-1:0]        irq_out,
   output logic [NUM_CHAN*FILT_W-1:0] filt_sel
);
   localparam int SELW   = sel_width(LAYOUT);
   localparam int PAD_SP = 1 << SELW;

   if (LAYOUT != 0 && LAYOUT != 1) begin : g_bad_layout
      $error("LAYOUT must be 0 or 1");
   end
   if (NUM_CHAN < 1 || NUM_CHAN > 8) begin : g_bad_chan
      $error("NUM_CHAN must be 1..8");
   end
   if (NUM_PADS < 1 || NUM_PADS > PAD_SP) begin : g_bad_pads
      $error("NUM_PADS exceeds selector range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_PADS-1:0]      pad_s;
   logic [PAD_SP-1:0]        pad_ext;
   logic [NUM_CHAN*SELW-1:0] cfg_sel;
   logic [NUM_CHAN-1:0]      cfg_edge;
   logic [NUM_CHAN-1:0]      cfg_both;
   logic [NUM_CHAN-1:0]      cfg_inv;
   logic                     glb_en;

   padirq_sync #(.W(NUM_PADS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
   );

   always_comb begin
      pad_ext = '0;
      pad_ext[NUM_PADS-1:0] = pad_s;
   end

   padirq_regs #(
      .LAYOUT(LAYOUT), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .SELW(SELW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_q(cfg_sel),
      .edge_q(cfg_edge), .both_q(cfg_both), .inv_q(cfg_inv),
      .filt_q(filt_sel), .glb_en(glb_en)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [SELW-1:0] sel_c;
      assign sel_c = cfg_sel[c*SELW +: SELW];
      padirq_chan #(.SELW(SELW)) u_chan (
         .clk(clk), .rst_n(rst_n), .lvl(pad_ext[sel_c]), .sel(sel_c),
         .edge_en(cfg_edge[c]), .both_en(cfg_both[c]), .inv_en(cfg_inv[c]),
         .gate(glb_en), .irq(irq_out[c])
      );
   end
endmodule

// File: rtl/padirq_mux_chk.sv
module padirq_mux_chk
   import padirq_pkg::*;
#(
   parameter int LAYOUT   = 0,
   parameter int NUM_CHAN = 8,
   parameter int ADDR_W   = 8,
   parameter int SELW     = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_wr,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [31:0]              reg_wdata,
   input logic [NUM_CHAN-1:0]      irq_out,
   input logic [NUM_CHAN*SELW-1:0] sel_flat,
   input logic [NUM_CHAN-1:0]      edge_en,
   input logic [NUM_CHAN-1:0]      both_en,
   input logic [NUM_CHAN-1:0]      inv_en,
   input logic                     glb_en
);
   logic mapped;
   logic unused_chk;
   assign unused_chk = ^reg_wdata;

   always_comb begin
      mapped = (reg_addr == ADDR_W'(TRIG_ADDR)) || (reg_addr == ADDR_W'(filt_addr(LAYOUT)));
      for (int c = 0; c < NUM_CHAN; c++)
         if (reg_addr == ADDR_W'(sel_addr(LAYOUT, c))) mapped = 1'b1;
   end

   a_r2_trig_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == ADDR_W'(TRIG_ADDR) |=>
         edge_en == $past(reg_wdata[EDGE_LSB +: NUM_CHAN]) &&
         both_en == $past(reg_wdata[BOTH_LSB +: NUM_CHAN]) &&
         inv_en  == $past(reg_wdata[INV_LSB +: NUM_CHAN]));

   a_r5_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !mapped |=> $stable(sel_flat) && $stable(edge_en) &&
         $stable(both_en) && $stable(inv_en) && $stable(glb_en));

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_sw
      a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_flat[c*SELW +: SELW] != $past(sel_flat[c*SELW +: SELW])) &&
         (edge_en[c] || both_en[c]) |=> !irq_out[c]);
   end

   if (LAYOUT == 0) begin : g_l0
      a_r3_sel_ch0: assert property (@(posedge clk) disable iff (!rst_n)
         reg_wr && reg_addr == ADDR_W'(4) |=> sel_flat[SELW-1:0] == $past(reg_wdata[SELW-1:0]));
   end else begin : g_l1
      a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
         !glb_en && !$past(glb_en) |-> irq_out == '0);
      a_r11_sel_ch1: assert property (@(posedge clk) disable iff (!rst_n)
         reg_wr && reg_addr == ADDR_W'(4) |=> sel_flat[SELW +: SELW] == $past(reg_wdata[16 +: SELW]));
   end
endmodule

bind padirq_mux padirq_mux_chk #(
   .LAYOUT(LAYOUT), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .SELW(SELW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq_out(irq_out), .sel_flat(cfg_sel),
   .edge_en(cfg_edge), .both_en(cfg_both), .inv_en(cfg_inv), .glb_en(glb_en)
);

// File: tb/tb_padirq_mux.sv
module tb_padirq_mux;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         wr_a = 1'b0, wr_b = 1'b0;
   logic [7:0]   addr_a = '0, addr_b = '0;
   logic [31:0]  wdata_a = '0, wdata_b = '0;
   logic [31:0]  rdata_a, rdata_b;
   logic [255:0] pads_a = '0;
   logic [127:0] pads_b = '0;
   logic [7:0]   irq_a, irq_b;
   logic [31:0]  filt_a, filt_b;

   padirq_mux dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(addr_a),
      .reg_wdata(wdata_a), .reg_rdata(rdata_a), .pad_in(pads_a),
      .irq_out(irq_a), .filt_sel(filt_a)
   );

   padirq_mux #(.LAYOUT(1), .NUM_PADS(128)) dut_alt (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(addr_b),
      .reg_wdata(wdata_b), .reg_rdata(rdata_b), .pad_in(pads_b),
      .irq_out(irq_b), .filt_sel(filt_b)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      if (alt) begin wr_b = 1'b1; addr_b = a; wdata_b = d; end
      else     begin wr_a = 1'b1; addr_a = a; wdata_a = d; end
      @(negedge clk);
      wr_a = 1'b0; wr_b = 1'b0;
   endtask

   task automatic rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      if (alt) addr_b = a; else addr_a = a;
      #1;
      d = alt ? rdata_b : rdata_a;
   endtask

   task automatic count(input int ch, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq_a[ch]) cnt++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, 8'h00, v); chk("R1 trig", v, 0);
      rd(0, 8'h04, v); chk("R1 sel03", v, 0);
      rd(0, 8'h08, v); chk("R1 sel47", v, 0);
      rd(0, 8'h0c, v); chk("R1 filt", v, 0);
      chk("R1 irq", {24'h0, irq_a}, 0);
      chk("R1 filt_sel", filt_a, 0);
   endtask

   task automatic t_trig_lanes();
      logic [31:0] v;
      wr(0, 8'h00, 32'hFFFF_FFFF);
      rd(0, 8'h00, v); chk("R2 lanes", v, 32'h00FF_FFFF);
      wr(0, 8'h00, 32'h0);
   endtask

   task automatic t_select();
      logic [31:0] v;
      wr(0, 8'h04, 32'h4030_2010);
      wr(0, 8'h08, 32'h8070_6050);
      rd(0, 8'h04, v); chk("R3 sel03", v, 32'h4030_2010);
      rd(0, 8'h08, v); chk("R3 sel47", v, 32'h8070_6050);
      @(negedge clk); pads_a[8'h30] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 route ch2", {24'h0, irq_a}, 32'h04);
      pads_a[8'h30] = 1'b0; pads_a[8'h70] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 route ch6", {24'h0, irq_a}, 32'h40);
      pads_a[8'h70] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 level low", {24'h0, irq_a}, 0);
   endtask

   task automatic t_filter();
      logic [31:0] v;
      wr(0, 8'h0c, 32'h8765_4321);
      chk("R4 filt_sel", filt_a, 32'h8765_4321);
      rd(0, 8'h0c, v); chk("R4 readback", v, 32'h8765_4321);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(0, 8'h10, 32'hFFFF_FFFF);
      wr(0, 8'h05, 32'hFFFF_FFFF);
      rd(0, 8'h10, v); chk("R5 read unmapped", v, 0);
      rd(0, 8'h04, v); chk("R5 sel untouched", v, 32'h4030_2010);
      rd(0, 8'h00, v); chk("R5 trig untouched", v, 0);
      chk("R5 filt untouched", filt_a, 32'h8765_4321);
   endtask

   task automatic t_level_inv();
      wr(0, 8'h04, 32'h0000_0001);
      wr(0, 8'h08, 32'h0);
      wr(0, 8'h00, 32'h0001_0000);
      @(negedge clk);
      chk("R6 inverted low pad", {31'h0, irq_a[0]}, 1);
      pads_a[1] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 inverted high pad", {31'h0, irq_a[0]}, 0);
      pads_a[1] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_edge();
      int n;
      wr(0, 8'h00, 32'h0000_0001);
      repeat (2) @(negedge clk);
      pads_a[1] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 no early pulse", {31'h0, irq_a[0]}, 0);
      @(negedge clk);
      chk("R7 rise pulse", {31'h0, irq_a[0]}, 1);
      @(negedge clk);
      chk("R7 pulse one cycle", {31'h0, irq_a[0]}, 0);
      pads_a[1] = 1'b0;
      count(0, 6, n); chk("R7 fall ignored in rise mode", n, 0);
      wr(0, 8'h00, 32'h0001_0001);
      repeat (2) @(negedge clk);
      pads_a[1] = 1'b1;
      count(0, 6, n); chk("R7 rise ignored in fall mode", n, 0);
      pads_a[1] = 1'b0;
      count(0, 6, n); chk("R7 fall pulse", n, 1);
   endtask

   task automatic t_both();
      int n;
      wr(0, 8'h00, 32'h0001_0101);
      repeat (2) @(negedge clk);
      pads_a[1] = 1'b1;
      count(0, 6, n); chk("R8 rise pulse", n, 1);
      pads_a[1] = 1'b0;
      count(0, 6, n); chk("R8 fall pulse", n, 1);
   endtask

   task automatic t_switch();
      int n;
      wr(0, 8'h00, 32'h0000_0001);
      pads_a[5] = 1'b1;
      repeat (4) @(negedge clk);
      wr(0, 8'h04, 32'h0000_0005);
      count(0, 5, n); chk("R9 switch to high pad", n, 0);
      pads_a[6] = 1'b1;
      wr(0, 8'h04, 32'h0000_0006);
      count(0, 5, n); chk("R9 coincident edge", n, 0);
      pads_a[6] = 1'b0;
      count(0, 5, n); chk("R9 fall after switch", n, 0);
      pads_a[6] = 1'b1;
      count(0, 6, n); chk("R9 later edge seen", n, 1);
   endtask

   task automatic t_alt();
      logic [31:0] v;
      pads_b[0] = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 gated at reset", {24'h0, irq_b}, 0);
      wr(1, 8'h00, 32'h8000_0000);
      chk("R10 not yet on", {24'h0, irq_b}, 0);
      @(negedge clk);
      chk("R10 enabled", {24'h0, irq_b}, 32'hFF);
      rd(1, 8'h00, v); chk("R10 readback", v, 32'h8000_0000);
      pads_b[0] = 1'b0;
      wr(1, 8'h04, 32'hFFFF_FFFF);
      rd(1, 8'h04, v); chk("R11 pair packing", v, 32'h007F_007F);
      wr(1, 8'h04, 32'h0006_0005);
      pads_b[6] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 odd channel route", {24'h0, irq_b}, 32'h02);
      wr(1, 8'h14, 32'h1234_5678);
      chk("R11 filter offset", filt_b, 32'h1234_5678);
      wr(1, 8'h00, 32'h0);
      repeat (2) @(negedge clk);
      chk("R10 disabled", {24'h0, irq_b}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_trig_lanes();
      t_select();
      t_filter();
      t_unmapped();
      t_level_inv();
      t_edge();
      t_both();
      t_switch();
      t_alt();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule